// File: doc/BRIEF.md
# Sequential 24-bit Float Adder-Subtractor

This block adds or subtracts two numbers held in a compact 24-bit floating-point word. The word has a sign bit, a 7-bit two's-complement exponent and a 16-bit mantissa whose leading one is stored explicitly. An operation starts with a single-cycle `start_i` pulse. The block then works through alignment, the mantissa add or subtract, and a one-bit-per-cycle normaliser. It finishes with a one-cycle `done_o` pulse.

The result word and the overflow flag stay unchanged between completions. One operation runs at a time. While a `start_i` pulse is being processed, further pulses are ignored. Rounding is a single round-half-up: when the smaller operand is aligned, and when a carry-out shifts the sum right. There is no special-value handling. The normaliser stops at the most negative exponent.

Top module: `fpas_core`

## Requirements
- R1: Word layout: bit 23 is the sign, bits 22:16 are the exponent in two's complement (00h is 2^0, 7Fh is 2^-1, 3Fh is the largest, 40h the smallest), and bits 15:0 are the mantissa, with bit 15 weighted 1.0. After reset, `done_o` and `ovf_o` are 0 and `result_o` is zero.
- R2: When `op_sub_i` is 1, the sign of operand b is inverted and the operands are then added.
- R3: The operand with the smaller exponent is shifted right by the exponent difference, and the last bit shifted out is added back into it. The result exponent is the larger exponent.
- R4: When the exponent difference is 16 or more, the result is the larger-exponent operand unchanged, with the b sign taken after the R2 inversion.
- R5: With equal signs, the aligned mantissas are added. On a carry-out, the 17-bit sum is shifted right by one, its old bit 0 is added back in, and the exponent goes up by one.
- R6: With differing signs, the aligned b mantissa is subtracted from the aligned a mantissa, and the result takes a's sign. On a borrow, the difference is negated and the result sign is the inverse of a's sign.
- R7: A nonzero mantissa is shifted left one bit per cycle, and the exponent is decremented each time. This continues until bit 15 is set or the exponent reaches 40h.
- R8: If the carry increment of R5 would take the exponent past 3Fh, the result is the computed sign, exponent 3Fh and mantissa FFFFh, and `ovf_o` is 1. Otherwise `ovf_o` is 0.
- R9: A zero mantissa after the add or subtract gives a result word of 000000h, with no normalising steps.
- R10: Let the edge that samples `start_i` be edge k. `done_o` is high for exactly one cycle. It rises at edge k+3+n, where n is the number of normalising shifts, or at edge k+2 for a saturated result. `result_o` and `ovf_o` change only at that edge.
- R11: A `start_i` pulse that arrives while an operation is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; operands are sampled on this edge |
| op_sub_i | input | 1 | 1 selects a minus b, 0 selects a plus b |
| a_i | input | 24 | First operand |
| b_i | input | 24 | Second operand |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Last result saturated on exponent overflow |
| result_o | output | 24 | Last completed result |

## Verification
The assertions rely on two properties of the block's own sequencing. First, `done_o` can only follow a `start_i` taken while idle, and the FSM passes through at least two cycles after that. Second, the result register is written only on the completing edge. They also take as given that operands carry an explicit leading one in bit 15, because the pass-through of R4 and the latency of R10 assume normalised inputs. The stimulus therefore builds every operand with bit 15 set. It raises `start_i` only when the previous result has been collected, except in the deliberate busy-time pulse used for R11.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
    localparam int unsigned EXP_W  = 7;
    localparam int unsigned MAN_W  = 16;
    localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;
    localparam int unsigned STEP_W = $clog2(MAN_W + 1);
    localparam int unsigned DIFF_W = EXP_W + 1;

    localparam logic [EXP_W-1:0] EXP_MAX = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_ARITH = 2'd2,
        ST_NORM  = 2'd3
    } fpas_state_e;

    typedef struct packed {
        fpas_state_e         state;
        logic                sa;
        logic                sb;
        logic [EXP_W-1:0]    ea;
        logic [EXP_W-1:0]    eb;
        logic [MAN_W-1:0]    ma;
        logic [MAN_W-1:0]    mb;
        logic                rs;
        logic [EXP_W-1:0]    re;
        logic [MAN_W-1:0]    rm;
        logic [STEP_W-1:0]   steps;
        logic [WORD_W-1:0]   res;
        logic                done;
        logic                ovf;
    } fpas_regs_t;
endpackage

// File: rtl/fpas_align.sv
module fpas_align
    import fpas_pkg::*;
(
    input  logic [EXP_W-1:0] ea_i,
    input  logic [EXP_W-1:0] eb_i,
    input  logic [MAN_W-1:0] ma_i,
    input  logic [MAN_W-1:0] mb_i,
    output logic [EXP_W-1:0] e_o,
    output logic [MAN_W-1:0] ma_o,
    output logic [MAN_W-1:0] mb_o
);
    logic signed [DIFF_W-1:0] diff;
    logic [DIFF_W-1:0]        mag;
    logic                     a_big;

    // shift right by d and add back the last bit dropped
    function automatic logic [MAN_W-1:0] shr_round(input logic [MAN_W-1:0] m,
                                                   input logic [DIFF_W-1:0] d);
        logic [MAN_W-1:0] part;
        logic [MAN_W-1:0] r;
        part = '0;
        if (d >= DIFF_W'(MAN_W)) begin
            r = '0;
        end else if (d == '0) begin
            r = m;
        end else begin
            part = m >> (d - DIFF_W'(1));
            r = (part >> 1) + {{(MAN_W-1){1'b0}}, part[0]};
        end
        return r;
    endfunction

    always_comb begin
        diff  = $signed({ea_i[EXP_W-1], ea_i}) - $signed({eb_i[EXP_W-1], eb_i});
        a_big = !diff[DIFF_W-1];
        mag   = a_big ? diff : -diff;
        e_o   = a_big ? ea_i : eb_i;
        ma_o  = a_big ? ma_i : shr_round(ma_i, mag);
        mb_o  = a_big ? shr_round(mb_i, mag) : mb_i;
    end
endmodule

// File: rtl/fpas_addsub.sv
module fpas_addsub
    import fpas_pkg::*;
(
    input  logic             sa_i,
    input  logic             sb_i,
    input  logic [EXP_W-1:0] e_i,
    input  logic [MAN_W-1:0] ma_i,
    input  logic [MAN_W-1:0] mb_i,
    output logic             s_o,
    output logic [EXP_W-1:0] e_o,
    output logic [MAN_W-1:0] m_o,
    output logic             sat_o
);
    logic [MAN_W:0] sum;
    logic [MAN_W:0] dif;

    always_comb begin
        sum   = {1'b0, ma_i} + {1'b0, mb_i};
        dif   = {1'b0, ma_i} - {1'b0, mb_i};
        s_o   = sa_i;
        e_o   = e_i;
        sat_o = 1'b0;
        if (sa_i == sb_i) begin
            if (sum[MAN_W]) begin
                m_o   = sum[MAN_W:1] + {{(MAN_W-1){1'b0}}, sum[0]};
                e_o   = e_i + EXP_W'(1);
                sat_o = (e_i == EXP_MAX);
            end else begin
                m_o = sum[MAN_W-1:0];
            end
        end else begin
            if (dif[MAN_W]) begin
                m_o = -dif[MAN_W-1:0];
                s_o = ~sa_i;
            end else begin
                m_o = dif[MAN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/fpas_core.sv
module fpas_core
    import fpas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_sub_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic              done_o,
    output logic              ovf_o,
    output logic [WORD_W-1:0] result_o
);
    fpas_regs_t q, d;

    logic [EXP_W-1:0] al_e;
    logic [MAN_W-1:0] al_ma, al_mb;
    logic             as_s, as_sat;
    logic [EXP_W-1:0] as_e;
    logic [MAN_W-1:0] as_m;

    fpas_align u_align (
        .ea_i (q.ea),
        .eb_i (q.eb),
        .ma_i (q.ma),
        .mb_i (q.mb),
        .e_o  (al_e),
        .ma_o (al_ma),
        .mb_o (al_mb)
    );

    fpas_addsub u_addsub (
        .sa_i  (q.sa),
        .sb_i  (q.sb),
        .e_i   (q.re),
        .ma_i  (q.ma),
        .mb_i  (q.mb),
        .s_o   (as_s),
        .e_o   (as_e),
        .m_o   (as_m),
        .sat_o (as_sat)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.sa    = a_i[WORD_W-1];
                    d.ea    = a_i[WORD_W-2 -: EXP_W];
                    d.ma    = a_i[MAN_W-1:0];
                    d.sb    = b_i[WORD_W-1] ^ op_sub_i;
                    d.eb    = b_i[WORD_W-2 -: EXP_W];
                    d.mb    = b_i[MAN_W-1:0];
                    d.state = ST_ALIGN;
                end
            end
            ST_ALIGN: begin
                d.ma    = al_ma;
                d.mb    = al_mb;
                d.re    = al_e;
                d.state = ST_ARITH;
            end
            ST_ARITH: begin
                if (as_sat) begin
                    d.res   = {as_s, EXP_MAX, {MAN_W{1'b1}}};
                    d.ovf   = 1'b1;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.rs    = as_s;
                    d.re    = as_e;
                    d.rm    = as_m;
                    d.steps = '0;
                    d.state = ST_NORM;
                end
            end
            ST_NORM: begin
                if (q.rm == '0) begin
                    d.res   = '0;
                    d.ovf   = 1'b0;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else if (q.rm[MAN_W-1] || q.re == EXP_MIN ||
                             q.steps == STEP_W'(MAN_W)) begin
                    d.res   = {q.rs, q.re, q.rm};
                    d.ovf   = 1'b0;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.rm    = q.rm << 1;
                    d.re    = q.re - EXP_W'(1);
                    d.steps = q.steps + STEP_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o   = q.done;
    assign ovf_o    = q.ovf;
    assign result_o = q.res;
endmodule

// File: rtl/fpas_chk.sv
module fpas_chk
    import fpas_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              done_i,
    input logic              ovf_i,
    input logic [WORD_W-1:0] res_i
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i); // R10
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |-> ($stable(res_i) && $stable(ovf_i))); // R10
    AST_SAT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ovf_i) |-> (res_i[MAN_W-1:0] == {MAN_W{1'b1}} &&
                               res_i[WORD_W-2 -: EXP_W] == EXP_MAX)); // R8
    AST_NORMALISED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ovf_i && res_i[MAN_W-1:0] != '0) |->
        (res_i[MAN_W-1] || res_i[WORD_W-2 -: EXP_W] == EXP_MIN)); // R7
    AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && res_i[MAN_W-1:0] == '0) |-> (res_i == '0)); // R9
endmodule

bind fpas_core fpas_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_i (done_o),
    .ovf_i  (ovf_o),
    .res_i  (result_o)
);

// File: tb/fpas_core_tb_top.sv
module fpas_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_sub_i = 1'b0;
    logic [23:0] a_i = '0;
    logic [23:0] b_i = '0;
    logic        done_o, ovf_o;
    logic [23:0] result_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [23:0] held_r = '0;
    logic        held_o = 1'b0;

    always #10 clk = ~clk;

    fpas_core dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sub_i(op_sub_i),
        .a_i(a_i), .b_i(b_i), .done_o(done_o), .ovf_o(ovf_o), .result_o(result_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic int rshr(input int m, input int dd);
        if (dd >= 16) return 0;
        if (dd == 0)  return m;
        return (m >> dd) + ((m >> (dd - 1)) & 1);
    endfunction

    // behavioural reference: value of result, overflow and done latency
    task automatic model(input logic [23:0] a, input logic [23:0] b, input bit op,
                         output logic [23:0] r, output bit o, output int lat);
        int ea, eb, ma, mb, e, m, dd, s;
        bit sa, sb;
        sa = a[23]; sb = b[23] ^ op;
        ea = int'($signed(a[22:16])); eb = int'($signed(b[22:16]));
        ma = int'(a[15:0]); mb = int'(b[15:0]);
        dd = ea - eb;
        if (dd >= 0) begin e = ea; mb = rshr(mb, dd); end
        else begin e = eb; ma = rshr(ma, -dd); end
        o = 1'b0;
        if (sa == sb) begin
            m = ma + mb; s = sa;
            if (m > 65535) begin
                m = (m >> 1) + (m & 1);
                e = e + 1;
                if (e > 63) begin
                    r = {sa, 7'h3F, 16'hFFFF}; o = 1'b1; lat = 2;
                    return;
                end
            end
        end else begin
            m = ma - mb;
            if (m < 0) begin m = -m; s = !sa; end
            else s = sa;
        end
        if (m == 0) begin r = '0; lat = 3; return; end
        lat = 3;
        while (m < 32768 && e > -64) begin m = m * 2; e = e - 1; lat++; end
        r = {s[0], 7'(e), 16'(m)};
    endtask

    task automatic run(input logic [23:0] a, input logic [23:0] b, input bit op,
                       input string req, input bit poke);
        logic [23:0] r; bit o; int lat;
        model(a, b, op, r, o, lat);
        @(negedge clk);
        a_i = a; b_i = b; op_sub_i = op; start_i = 1'b1;
        @(negedge clk);
        if (poke) begin
            a_i = 24'h3F8000; b_i = 24'h3F8000; op_sub_i = 1'b0; start_i = 1'b1;
        end else start_i = 1'b0;
        for (int j = 1; j <= lat + 1; j++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (j == lat) begin held_r = r; held_o = o; end
            chk(done_o == (j == lat), req, "done", 32'(done_o), 32'(j == lat));
            chk(result_o == held_r, req, "result", 32'(result_o), 32'(held_r));
            chk(ovf_o == held_o, req, "ovf", 32'(ovf_o), 32'(held_o));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done_o == 1'b0, "R1", "done", 32'(done_o), 0);
        chk(ovf_o == 1'b0, "R1", "ovf", 32'(ovf_o), 0);
        chk(result_o == 24'h0, "R1", "result", 32'(result_o), 0);
        rst_n = 1'b1;
        run(24'h008000, 24'h018000, 1'b0, "R3", 1'b0);      // 1+2=3
        run(24'h7F8000, 24'h008000, 1'b0, "R1", 1'b0);      // 0.5+1
        run(24'h018000, 24'h008001, 1'b0, "R3", 1'b0);      // round on align
        run(24'h01C000, 24'h018000, 1'b0, "R5", 1'b0);      // carry
        run(24'h00FFFF, 24'h008000, 1'b0, "R5", 1'b0);      // carry round
        run(24'h008000, 24'h018000, 1'b1, "R2", 1'b0);      // 1-2
        run(24'h018000, 24'h808000, 1'b0, "R6", 1'b0);      // 2+(-1)
        run(24'h008000, 24'h018000, 1'b0, "R6", 1'b0);
        run(24'h808000, 24'h018000, 1'b0, "R6", 1'b0);      // borrow flips sign
        run(24'h149234, 24'h008000, 1'b0, "R4", 1'b0);
        run(24'h008000, 24'h149234, 1'b1, "R4", 1'b0);
        run(24'h00A5A5, 24'h00A5A5, 1'b1, "R9", 1'b0);
        run(24'h3F8000, 24'h3F8000, 1'b0, "R8", 1'b0);
        run(24'hBF8000, 24'hBFC000, 1'b0, "R8", 1'b0);
        run(24'h3E8000, 24'h3E8000, 1'b0, "R8", 1'b0);      // no saturation
        run(24'h40C000, 24'h408000, 1'b1, "R7", 1'b0);      // exponent floor
        run(24'h418001, 24'h418000, 1'b1, "R7", 1'b0);      // floor mid-shift
        run(24'h008001, 24'h008000, 1'b1, "R7", 1'b0);      // 15 shifts
        run(24'h028000, 24'h018000, 1'b0, "R11", 1'b1);     // busy start ignored
        run(24'h008000, 24'h008000, 1'b0, "R10", 1'b0);
        for (int i = 0; i < 400; i++) begin
            logic [23:0] ra, rb;
            int xa, xb;
            xa = int'($urandom_range(40)) - 20;
            xb = xa + int'($urandom_range(36)) - 18;
            ra = {1'($urandom), 7'(xa), 16'h8000 | 16'($urandom)};
            rb = {1'($urandom), 7'(xb), 16'h8000 | 16'($urandom)};
            run(ra, rb, 1'($urandom), "R10", 1'b0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule